// File: doc/BRIEF.md
# Half-rate DDR write issue logic

This block belongs to a custom DDR/DDR2 memory controller and runs on the half-rate controller clock. Each controller cycle carries two memory-clock slots, and the slot in the low bit goes out first. The block accepts one write request at a time through a valid/ready handshake. A request holds a row/column address, eight data beats and their byte masks. From it the block builds the paired-slot signals that the physical layer serialises: a 2-bit active-low select that places the command in the second slot, an address bus that repeats the address in both halves, a 2-bit DQS enable, a per-slot write-data-valid strobe, the write data and the data masks.

The data phase is two controller cycles long, which makes a burst of eight at the memory. It starts a number of controller cycles after the command. That number comes from a latency input that the physical layer supplies once calibration has finished, and it does not change during normal operation. The DQS enable begins one slot ahead of the data. Writes spaced exactly two controller cycles apart produce one unbroken DQS window. A build parameter selects a power-saving variant. In that variant the strobe is dropped in slots where every byte is masked, so the DQ pins stay undriven there.

Top module: `ddr_hr_write_issue`

## Requirements
- R1: While reset is active and until calibration completes, `phy_cs_n` is 2'b11, `phy_dqs_en`, `phy_wdata_valid`, `phy_wdata` and `phy_dm` are zero, and `req_ready` is low.
- R2: `req_ready` stays low while `cal_done` is low, and no request is taken then.
- R3: In the cycle after a request is accepted, `req_ready` is low. Accepted requests are therefore at least two controller cycles apart.
- R4: In the controller cycle after an acceptance, `phy_cs_n` is 2'b01, which puts the active select in the second slot. In every other cycle it is 2'b11.
- R5: While `phy_cs_n` is not 2'b11, `phy_addr` equals the accepted address in both its lower and its upper half.
- R6: Call the command cycle C. The first data cycle is C+`wlat` and the second is C+`wlat`+1. `phy_wdata` carries request beats 0-3 in the first data cycle and beats 4-7 in the second. Beat b of the request is `req_wdata[b*DQ_W +: DQ_W]`, and within a cycle beat 0 sits in the least significant bits.
- R7: `phy_dm` carries the masks of the same beats in the same layout. A 1 means that byte is not written.
- R8: In the default mode, `phy_wdata_valid` is 2'b11 in both data cycles, whatever the masks are.
- R9: In the power-saving mode, bit j of `phy_wdata_valid` in a data cycle is 0 exactly when every mask bit of beats 2j and 2j+1 of that cycle is 1.
- R10: `phy_dqs_en` is 2'b11 in every data cycle. It is 2'b10 in a cycle that is not a data cycle but is followed by one. Otherwise it is 2'b00. Writes spaced two cycles apart therefore keep DQS continuous.
- R11: `wlat` lies in 1..2^WLAT_W-1 and holds steady while `cal_done` is high.
- R12: Outside data cycles, `phy_wdata_valid`, `phy_wdata` and `phy_dm` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-rate controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cal_done | input | 1 | Calibration has completed; `wlat` is valid |
| wlat | input | WLAT_W | Write latency in controller cycles from the command to the first data |
| req_valid | input | 1 | A write request is offered |
| req_ready | output | 1 | The block takes the request on this edge |
| req_addr | input | ADDR_W | Memory address of the write |
| req_wdata | input | 8*DQ_W | Eight beats of data, beat 0 in the LSBs |
| req_mask | input | 8*DQ_W/8 | Byte masks of the eight beats, 1 = do not write |
| phy_cs_n | output | 2 | Active-low select per slot, bit 0 first |
| phy_addr | output | 2*ADDR_W | Address repeated over both slots |
| phy_dqs_en | output | 2 | DQS burst enable per slot, bit 0 first |
| phy_wdata_valid | output | 2 | Write data valid per slot |
| phy_wdata | output | 4*DQ_W | Four beats of write data for this cycle |
| phy_dm | output | 4*DQ_W/8 | Byte masks of those four beats |

## Verification
The state that can go wrong is the pending second half and the delay line that holds data for `wlat` cycles. A lost or doubled second half shows up at the ports within `wlat`+2 cycles of the command as a missing, shifted or repeated data cycle. It also shows up in the DQS pattern around that cycle. A wrong tap or a skipped stage moves the whole data phase against the expected command-plus-latency slot. That shift is caught on the first write after calibration, at every latency tried, including the minimum of one and the maximum. A pending flag that fails to clear leaves `req_ready` stuck low, so no later select ever reaches `phy_cs_n` and every following expected command is missed.

// File: rtl/ddr_hr_wr_pkg.sv
package ddr_hr_wr_pkg;
  // memory-clock slots carried by one controller cycle
  localparam int SLOTS          = 2;
  // data beats (both DQS edges) in one slot
  localparam int BEATS_PER_SLOT = 2;
  localparam int BEATS_PER_CYC  = SLOTS * BEATS_PER_SLOT;
  // controller cycles of data per write burst
  localparam int BURST_CYC      = 2;

  typedef enum logic [1:0] {
    DQS_OFF  = 2'b00,
    DQS_LEAD = 2'b10,  // slot 0 quiet, slot 1 opens the preamble
    DQS_FULL = 2'b11
  } dqs_code_e;

  localparam logic [1:0] CS_IDLE = 2'b11;
  localparam logic [1:0] CS_LATE = 2'b01;  // select low in the second slot
endpackage

// File: rtl/ddr_hr_wr_accept.sv
module ddr_hr_wr_accept
  import ddr_hr_wr_pkg::*;
#(
  parameter  int ADDR_W = 13,
  parameter  int DQ_W   = 16,
  parameter  int DM_W   = 2,
  localparam int CYC_D  = BEATS_PER_CYC * DQ_W,
  localparam int CYC_M  = BEATS_PER_CYC * DM_W
) (
  input  logic                    clk,
  input  logic                    arst_n,
  input  logic                    run,
  input  logic                    cal_done,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [BURST_CYC*CYC_D-1:0] req_wdata,
  input  logic [BURST_CYC*CYC_M-1:0] req_mask,
  output logic [1:0]              cs_n,
  output logic [2*ADDR_W-1:0]     addr_o,
  output logic                    lane_v,
  output logic [CYC_D-1:0]        lane_d,
  output logic [CYC_M-1:0]        lane_m
);

  logic                pend_q, pend_d;
  logic [CYC_D-1:0]    hold_d_q;
  logic [CYC_M-1:0]    hold_m_q;
  logic                hold_en;
  logic [1:0]          cs_q, cs_d;
  logic [2*ADDR_W-1:0] addr_q, addr_d;
  logic                take;

  always_comb begin
    req_ready = run & cal_done & ~pend_q;
    take      = req_valid & req_ready;
    pend_d    = take;
    hold_en   = take;
    cs_d      = take ? CS_LATE : CS_IDLE;
    addr_d    = take ? {req_addr, req_addr} : addr_q;
    lane_v    = take | pend_q;
    lane_d    = take ? req_wdata[CYC_D-1:0] : hold_d_q;
    lane_m    = take ? req_mask[CYC_M-1:0]  : hold_m_q;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      pend_q <= 1'b0;
      cs_q   <= CS_IDLE;
      addr_q <= '0;
    end else begin
      pend_q <= pend_d;
      cs_q   <= cs_d;
      addr_q <= addr_d;
    end
  end

  // second half of the burst, no reset needed: qualified by pend_q
  always_ff @(posedge clk) begin
    if (hold_en) begin
      hold_d_q <= req_wdata[BURST_CYC*CYC_D-1:CYC_D];
      hold_m_q <= req_mask[BURST_CYC*CYC_M-1:CYC_M];
    end
  end

  assign cs_n   = cs_q;
  assign addr_o = addr_q;

endmodule

// File: rtl/ddr_hr_wr_delay.sv
module ddr_hr_wr_delay #(
  parameter  int PAY_W = 72,
  parameter  int SEL_W = 4,
  localparam int TAPS  = 1 << SEL_W
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             in_v,
  input  logic [PAY_W-1:0] in_pay,
  input  logic [SEL_W-1:0] sel,
  output logic             now_v,
  output logic [PAY_W-1:0] now_pay,
  output logic             ahead_v
);

  logic [TAPS-1:0] tap_v;
  logic [PAY_W-1:0] tap_pay [TAPS];

  assign tap_v[0]   = in_v;
  assign tap_pay[0] = in_pay;

  for (genvar g = 1; g < TAPS; g++) begin : g_stage
    logic             v_q;
    logic [PAY_W-1:0] p_q;

    always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) v_q <= 1'b0;
      else         v_q <= tap_v[g-1];
    end

    // payload loads only with a valid beat pair
    always_ff @(posedge clk) begin
      if (tap_v[g-1]) p_q <= tap_pay[g-1];
    end

    assign tap_v[g]   = v_q;
    assign tap_pay[g] = p_q;
  end

  always_comb begin
    now_v   = tap_v[sel];
    now_pay = tap_pay[sel];
    ahead_v = (sel != '0) ? tap_v[sel - 1'b1] : 1'b0;
  end

endmodule

// File: rtl/ddr_hr_wr_strobe.sv
module ddr_hr_wr_strobe
  import ddr_hr_wr_pkg::*;
#(
  parameter  int DQ_W       = 16,
  parameter  int DM_W       = 2,
  parameter  bit POWER_SAVE = 1'b0,
  localparam int CYC_D      = BEATS_PER_CYC * DQ_W,
  localparam int CYC_M      = BEATS_PER_CYC * DM_W,
  localparam int SLOT_M     = BEATS_PER_SLOT * DM_W
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             now_v,
  input  logic [CYC_D-1:0] now_d,
  input  logic [CYC_M-1:0] now_m,
  input  logic             ahead_v,
  output logic [1:0]       dqs_en,
  output logic [SLOTS-1:0] wdata_valid,
  output logic [CYC_D-1:0] wdata,
  output logic [CYC_M-1:0] dm
);

  logic [SLOTS-1:0] live;

  for (genvar j = 0; j < SLOTS; j++) begin : g_slot
    if (POWER_SAVE) begin : g_ps
      assign live[j] = ~&now_m[j*SLOT_M +: SLOT_M];
    end else begin : g_full
      assign live[j] = 1'b1;
    end
  end

  dqs_code_e        dqs_d;
  logic [SLOTS-1:0] vld_d;
  logic [CYC_D-1:0] wd_d;
  logic [CYC_M-1:0] dm_d;

  always_comb begin
    if (now_v)        dqs_d = DQS_FULL;
    else if (ahead_v) dqs_d = DQS_LEAD;
    else              dqs_d = DQS_OFF;
    vld_d = now_v ? live  : '0;
    wd_d  = now_v ? now_d : '0;
    dm_d  = now_v ? now_m : '0;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      dqs_en      <= DQS_OFF;
      wdata_valid <= '0;
      wdata       <= '0;
      dm          <= '0;
    end else begin
      dqs_en      <= dqs_d;
      wdata_valid <= vld_d;
      wdata       <= wd_d;
      dm          <= dm_d;
    end
  end

endmodule

// File: rtl/ddr_hr_write_issue.sv
module ddr_hr_write_issue
  import ddr_hr_wr_pkg::*;
#(
  parameter  int ADDR_W     = 13,
  parameter  int DQ_W       = 16,
  parameter  int WLAT_W     = 4,
  parameter  bit POWER_SAVE = 1'b0,
  localparam int DM_W       = DQ_W / 8,
  localparam int CYC_D      = BEATS_PER_CYC * DQ_W,
  localparam int CYC_M      = BEATS_PER_CYC * DM_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cal_done,
  input  logic [WLAT_W-1:0]          wlat,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [ADDR_W-1:0]          req_addr,
  input  logic [BURST_CYC*CYC_D-1:0] req_wdata,
  input  logic [BURST_CYC*CYC_M-1:0] req_mask,
  output logic [1:0]                 phy_cs_n,
  output logic [2*ADDR_W-1:0]        phy_addr,
  output logic [1:0]                 phy_dqs_en,
  output logic [SLOTS-1:0]           phy_wdata_valid,
  output logic [CYC_D-1:0]           phy_wdata,
  output logic [CYC_M-1:0]           phy_dm
);

  // reset: asserts at once, leaves after two clean edges
  logic [1:0] rs_q;
  logic       arst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign arst_i_n = rs_q[1];

  logic             lane_v, now_v, ahead_v;
  logic [CYC_D-1:0] lane_d;
  logic [CYC_M-1:0] lane_m;
  logic [CYC_M+CYC_D-1:0] now_pay;

  ddr_hr_wr_accept #(
    .ADDR_W(ADDR_W), .DQ_W(DQ_W), .DM_W(DM_W)
  ) u_accept (
    .clk       (clk),
    .arst_n    (arst_i_n),
    .run       (arst_i_n),
    .cal_done  (cal_done),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_mask  (req_mask),
    .cs_n      (phy_cs_n),
    .addr_o    (phy_addr),
    .lane_v    (lane_v),
    .lane_d    (lane_d),
    .lane_m    (lane_m)
  );

  ddr_hr_wr_delay #(
    .PAY_W(CYC_M + CYC_D), .SEL_W(WLAT_W)
  ) u_delay (
    .clk     (clk),
    .arst_n  (arst_i_n),
    .in_v    (lane_v),
    .in_pay  ({lane_m, lane_d}),
    .sel     (wlat),
    .now_v   (now_v),
    .now_pay (now_pay),
    .ahead_v (ahead_v)
  );

  ddr_hr_wr_strobe #(
    .DQ_W(DQ_W), .DM_W(DM_W), .POWER_SAVE(POWER_SAVE)
  ) u_strobe (
    .clk         (clk),
    .arst_n      (arst_i_n),
    .now_v       (now_v),
    .now_d       (now_pay[CYC_D-1:0]),
    .now_m       (now_pay[CYC_M+CYC_D-1:CYC_D]),
    .ahead_v     (ahead_v),
    .dqs_en      (phy_dqs_en),
    .wdata_valid (phy_wdata_valid),
    .wdata       (phy_wdata),
    .dm          (phy_dm)
  );

endmodule

// File: rtl/ddr_hr_write_issue_chk.sv
module ddr_hr_write_issue_chk #(
  parameter  int ADDR_W     = 13,
  parameter  int DQ_W       = 16,
  parameter  int WLAT_W     = 4,
  parameter  bit POWER_SAVE = 1'b0,
  localparam int DM_W       = DQ_W / 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cal_done,
  input logic [WLAT_W-1:0]   wlat,
  input logic                req_valid,
  input logic                req_ready,
  input logic [1:0]          phy_cs_n,
  input logic [2*ADDR_W-1:0] phy_addr,
  input logic [1:0]          phy_dqs_en,
  input logic [1:0]          phy_wdata_valid,
  input logic [4*DQ_W-1:0]   phy_wdata,
  input logic [4*DM_W-1:0]   phy_dm
);

  AST_READY_NEEDS_CAL: assert property (@(posedge clk) disable iff (!rst_n)
    !cal_done |-> !req_ready); // R2

  AST_ACCEPT_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R3

  AST_CMD_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (phy_cs_n == 2'b01)); // R4

  AST_CMD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> (phy_cs_n == 2'b11)); // R4

  AST_ADDR_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_cs_n != 2'b11) |-> (phy_addr[ADDR_W-1:0] == phy_addr[2*ADDR_W-1:ADDR_W])); // R5

  AST_DQS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done |-> (phy_dqs_en != 2'b01)); // R10

  AST_DQS_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
    (|phy_wdata_valid) |-> (phy_dqs_en == 2'b11)); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_dqs_en == 2'b00) |-> (phy_wdata_valid == 2'b00 && phy_wdata == '0 && phy_dm == '0)); // R12

  AST_WLAT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done |-> (wlat != '0)); // R11

  AST_WLAT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_done && $past(cal_done)) |-> $stable(wlat)); // R11

  if (!POWER_SAVE) begin : g_full_chk
    AST_VALID_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
      (|phy_wdata_valid) |-> (&phy_wdata_valid)); // R8
  end

endmodule

bind ddr_hr_write_issue ddr_hr_write_issue_chk #(
  .ADDR_W(ADDR_W), .DQ_W(DQ_W), .WLAT_W(WLAT_W), .POWER_SAVE(POWER_SAVE)
) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .cal_done        (cal_done),
  .wlat            (wlat),
  .req_valid       (req_valid),
  .req_ready       (req_ready),
  .phy_cs_n        (phy_cs_n),
  .phy_addr        (phy_addr),
  .phy_dqs_en      (phy_dqs_en),
  .phy_wdata_valid (phy_wdata_valid),
  .phy_wdata       (phy_wdata),
  .phy_dm          (phy_dm)
);

// File: tb/ddr_hr_write_issue_bench.sv
module ddr_hr_write_issue_bench;
  localparam int AW   = 13;
  localparam int DW   = 16;
  localparam int MW   = DW / 8;
  localparam int LW   = 4;
  localparam int MAXC = 8192;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic              rst_n, cal_done, req_valid;
  logic [LW-1:0]     wlat;
  logic [AW-1:0]     req_addr;
  logic [8*DW-1:0]   req_wdata;
  logic [8*MW-1:0]   req_mask;
  logic              rdy, rdy_ps;
  logic [1:0]        cs_n, cs_n_ps, dqs, dqs_ps, vld, vld_ps;
  logic [2*AW-1:0]   addr, addr_ps;
  logic [4*DW-1:0]   wd, wd_ps;
  logic [4*MW-1:0]   dm, dm_ps;

  ddr_hr_write_issue #(.ADDR_W(AW), .DQ_W(DW), .WLAT_W(LW), .POWER_SAVE(1'b0)) u_ddr_hr_write_issue (
    .clk(clk), .rst_n(rst_n), .cal_done(cal_done), .wlat(wlat),
    .req_valid(req_valid), .req_ready(rdy), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_mask(req_mask),
    .phy_cs_n(cs_n), .phy_addr(addr), .phy_dqs_en(dqs),
    .phy_wdata_valid(vld), .phy_wdata(wd), .phy_dm(dm));

  ddr_hr_write_issue #(.ADDR_W(AW), .DQ_W(DW), .WLAT_W(LW), .POWER_SAVE(1'b1)) u_ddr_hr_write_issue_ps (
    .clk(clk), .rst_n(rst_n), .cal_done(cal_done), .wlat(wlat),
    .req_valid(req_valid), .req_ready(rdy_ps), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_mask(req_mask),
    .phy_cs_n(cs_n_ps), .phy_addr(addr_ps), .phy_dqs_en(dqs_ps),
    .phy_wdata_valid(vld_ps), .phy_wdata(wd_ps), .phy_dm(dm_ps));

  int n_chk = 0;
  int n_err = 0;
  int t     = 0;
  int lat   = 2;
  bit last_take = 1'b0;

  logic [1:0]      e_cs   [MAXC];
  logic [2*AW-1:0] e_addr [MAXC];
  logic            e_dv   [MAXC];
  logic [4*DW-1:0] e_wd   [MAXC];
  logic [4*MW-1:0] e_dm   [MAXC];

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s cycle %0d: actual %0h expected %0h", req, t, act, exp);
    end
  endtask

  // R9: slot j is live unless all mask bits of its two beats are set
  function automatic logic [1:0] ps_valid(input logic [4*MW-1:0] m);
    logic [1:0] r;
    for (int j = 0; j < 2; j++) r[j] = ~&m[j*2*MW +: 2*MW];
    return r;
  endfunction

  function automatic logic [1:0] exp_dqs(input int c);
    if (e_dv[c])        return 2'b11;
    else if (e_dv[c+1]) return 2'b10;
    else                return 2'b00;
  endfunction

  task automatic check_cycle(input int c);
    chk(cs_n == e_cs[c], "R4", cs_n, e_cs[c]);
    chk(cs_n_ps == e_cs[c], "R4", cs_n_ps, e_cs[c]);
    if (e_cs[c] == 2'b01) chk(addr == e_addr[c], "R5", addr, e_addr[c]);
    chk(dqs == exp_dqs(c), "R10", dqs, exp_dqs(c));
    chk(dqs_ps == exp_dqs(c), "R10", dqs_ps, exp_dqs(c));
    if (e_dv[c]) begin
      chk(wd == e_wd[c], "R6", wd, e_wd[c]);
      chk(dm == e_dm[c], "R7", dm, e_dm[c]);
      chk(vld == 2'b11, "R8", vld, 2'b11);
      chk(vld_ps == ps_valid(e_dm[c]), "R9", vld_ps, ps_valid(e_dm[c]));
    end else begin
      chk(vld == 2'b00 && wd == '0 && dm == '0, "R12", {vld, wd, dm}, 0);
      chk(vld_ps == 2'b00 && wd_ps == '0, "R12", {vld_ps, wd_ps}, 0);
    end
  endtask

  // drive at the negedge, step one edge, check the new state
  task automatic cycle(input bit v, input logic [AW-1:0] a, input logic [8*DW-1:0] d, input logic [8*MW-1:0] m);
    int k;
    bit take;
    req_valid = v; req_addr = a; req_wdata = d; req_mask = m;
    #1;
    chk(rdy == rdy_ps, "R3", rdy_ps, rdy);
    if (!cal_done) chk(!rdy, "R2", rdy, 0);
    if (last_take) chk(!rdy, "R3", rdy, 0);
    take = v && rdy;
    if (take) begin
      k = t + 1;
      e_cs[k] = 2'b01;
      e_addr[k] = {a, a};
      e_dv[k+lat] = 1'b1;   e_wd[k+lat] = d[4*DW-1:0];    e_dm[k+lat] = m[4*MW-1:0];
      e_dv[k+lat+1] = 1'b1; e_wd[k+lat+1] = d[8*DW-1:4*DW]; e_dm[k+lat+1] = m[8*MW-1:4*MW];
    end
    last_take = take;
    @(posedge clk);
    t++;
    @(negedge clk);
    check_cycle(t);
  endtask

  function automatic logic [8*MW-1:0] pick_mask();
    case ($urandom % 5)
      0: return 16'h0003;         // beats 0-1 partly masked, slot kept
      1: return 16'h000F;         // beats 0-1 fully masked
      2: return 16'hF0F0;         // beats 2-3 and 6-7 fully masked
      3: return 16'($urandom);
      default: return '0;
    endcase
  endfunction

  task automatic rnd_cycle(input bit v);
    cycle(v, AW'($urandom), {$urandom, $urandom, $urandom, $urandom}, pick_mask());
  endtask

  task automatic run_phase(input int l, input int n);
    cal_done = 1'b0;
    for (int i = 0; i < 24; i++) rnd_cycle(1'b0);
    lat = l; wlat = LW'(l); cal_done = 1'b1;
    for (int i = 0; i < 12; i++) rnd_cycle(1'b1);          // max rate: continuous DQS
    for (int i = 0; i < 12; i++) rnd_cycle(i % 3 == 0);    // spaced three apart: new preamble
    cycle(1'b1, '1, '1, 16'hFFFF);                         // every byte masked
    cycle(1'b0, '0, '0, '0);
    for (int i = 0; i < n; i++) rnd_cycle(($urandom % 3) != 0);
    for (int i = 0; i < 24; i++) rnd_cycle(1'b0);
  endtask

  initial begin
    #(5ns * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog cycle %0d: actual running expected done", t);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd41));
    for (int i = 0; i < MAXC; i++) begin
      e_cs[i] = 2'b11; e_addr[i] = '0; e_dv[i] = 1'b0; e_wd[i] = '0; e_dm[i] = '0;
    end
    rst_n = 1'b0; cal_done = 1'b0; wlat = 4'd2;
    req_valid = 1'b0; req_addr = '0; req_wdata = '0; req_mask = '0;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(cs_n == 2'b11 && dqs == 2'b00 && vld == 2'b00 && wd == '0 && dm == '0, "R1",
        {cs_n, dqs, vld}, 6'b110000);
    chk(!rdy && !rdy_ps, "R1", rdy, 0);
    rst_n = 1'b1;
    // R2: offers before calibration are refused
    for (int i = 0; i < 6; i++) rnd_cycle(1'b1);
    chk(cs_n == 2'b11 && !rdy, "R1", {cs_n, rdy}, 3'b110);
    run_phase(2, 300);
    run_phase(1, 300);
    run_phase(5, 300);
    run_phase(15, 300);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule